// File: doc/BRIEF.md
# Transmit Descriptor Ring Controller

This block keeps the host-side state of a circular transmit descriptor ring that is shared with a DMA engine. A frame request carries a length. When the block accepts one, it writes a control word into the descriptor at the producer index. The control word hands the descriptor to the engine through an owner bit and marks it as both first and last piece of the frame. The block then pulses a doorbell. The engine hands descriptors back by clearing their owner bit through a release port. On a reclaim request, the block walks forward from the consumer index and frees every descriptor that has been handed back, in order.

Two depths apply. The physical ring depth sets where the descriptor index wraps. The smaller logical depth bounds how many descriptors may be outstanding, and it also selects the buffer, which is the index modulo the logical depth. A mask for the completion interrupt follows the outstanding count with hysteresis. Queuing above a high-water mark unmasks it. Reclaiming below a low-water mark masks it again with all ones.

A watchdog is reloaded with five ticks whenever a frame is queued, and it is cleared when the ring drains. If it runs out, the block pulses a timeout. It then returns the indices, the count and the descriptor words to their reset values.

The controller moves through the following states and transitions:
- `ST_IDLE` waits.
- Transition *accept*: from `ST_IDLE` to `ST_POST`, on a valid request while the ring is not full.
- Transition *scan*: from `ST_IDLE` to `ST_SCAN`, on a reclaim request. A reclaim request has priority over a frame request.
- Transition *posted*: from `ST_POST` back to `ST_IDLE`. In `ST_POST` the descriptor is written and the doorbell rings.
- Transition *step*: from `ST_SCAN` to itself. Each step frees one descriptor.
- Transition *stop*: from `ST_SCAN` to `ST_IDLE`, when the descriptor at the consumer index is still owned or the count is zero.
- Transition *flush*: from any state to `ST_IDLE`, on a watchdog expiry.

Top module: `txr_ring_ctrl`

## Requirements
- R1: An accepted frame writes a 16-bit control word at the producer index with these fields:
  - bit 15 is the owner bit, set to 1.
  - bit 14 is start-of-packet, set to 1.
  - bit 13 is end-of-packet, set to 1.
  - bits 12:11 are 0.
  - bits 10:0 hold the frame length.
- R2: The `doorbell` is high for exactly one cycle per accepted frame. This is the cycle after the accepting edge, and `door_idx` then shows the descriptor index being written.
- R3: The producer index runs through 0..PHYS_DEPTH-1 and wraps to 0. While `doorbell` is high, `buf_sel` equals `door_idx` modulo LOG_DEPTH.
- R4: When `count` reaches LOG_DEPTH, `full` is 1 and `req_ready` is 0. A request held while the ring is full rings no doorbell and leaves `count` unchanged.
- R5: If the count after queuing a frame exceeds HI_WM, `irq_mask` becomes 0.
- R6: A reclaim stops at the first descriptor whose owner bit is still 1, or when `count` is 0. That descriptor keeps its owner bit.
- R7: Each reclaimed descriptor clears its owner bit in the store, lowers `count` by one, advances the consumer index and clears `full`.
- R8: When a reclaim ends with `count` below LO_WM, `irq_mask` becomes all ones. Between the watermarks, the mask keeps its value.
- R9: Each accepted frame loads the watchdog with WD_LOAD ticks, and each `tick` lowers it by one. A reclaim that drains the ring to zero clears it, so no timeout follows.
- R10: When the watchdog reaches zero, `timeout` pulses for one cycle. On the next edge the block clears `count`, `full`, both indices and all descriptor words, and sets `irq_mask` to all ones.
- R11: After reset, the outputs are as follows:
  - `count` is 0 and `full` is 0.
  - `irq_mask` is all ones.
  - `doorbell` and `timeout` are 0.
  - `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Frame request present |
| req_len | input | 11 | Frame length |
| req_ready | output | 1 | Request is accepted this cycle if valid |
| doorbell | output | 1 | Wake-up pulse toward the DMA engine |
| door_idx | output | $clog2(PHYS_DEPTH) | Descriptor index being written |
| buf_sel | output | $clog2(LOG_DEPTH) | Buffer slot for that descriptor |
| reclaim_req | input | 1 | Start a reclaim walk |
| rel_valid | input | 1 | Engine hands a descriptor back |
| rel_idx | input | $clog2(PHYS_DEPTH) | Index of the descriptor handed back |
| tick | input | 1 | Watchdog time base |
| timeout | output | 1 | Watchdog expiry pulse |
| full | output | 1 | Outstanding count at logical depth |
| count | output | $clog2(LOG_DEPTH+1) | Outstanding descriptors |
| irq_mask | output | MASK_W | Completion interrupt mask (all ones = masked) |
| obs_idx | input | $clog2(PHYS_DEPTH) | Descriptor select for observation |
| obs_word | output | 16 | Control word at `obs_idx` |

## Verification
Each result has its own due cycle:
- The doorbell, `door_idx` and `buf_sel` are due in the cycle after the edge that accepts a request.
- `count`, `full` and `irq_mask` change one edge later.
- Reclaim frees one descriptor per cycle, so its results are checked only after a wait longer than the physical depth.
- The timeout shows in the cycle after the edge that takes the last tick, and the clearing it causes shows one cycle after that.

The bench drives its inputs on falling edges and samples only at the falling edge where each result is due. Because of this, a result that arrives one cycle early or late fails a check.

// File: rtl/txr_pkg.sv
package txr_pkg;

    localparam int LEN_W = 11;

    typedef struct packed {
        logic             own;
        logic             sop;
        logic             eop;
        logic [1:0]       rsvd;
        logic [LEN_W-1:0] len;
    } txr_desc_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_POST = 2'd1,
        ST_SCAN = 2'd2
    } txr_state_t;

endpackage

// File: rtl/txr_ptr.sv
module txr_ptr #(
    parameter int DEPTH = 16,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [IW-1:0] idx
);
    localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

    logic [IW-1:0] idx_q;
    logic [IW-1:0] idx_nx;

    generate
        if (POW2) begin : g_pow2
            assign idx_nx = idx_q + 1'b1;
        end else begin : g_cmp
            assign idx_nx = (idx_q == IW'(DEPTH - 1)) ? '0 : idx_q + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    idx_q <= '0;
        else if (clr)  idx_q <= '0;
        else if (inc)  idx_q <= idx_nx;
    end

    assign idx = idx_q;
endmodule

// File: rtl/txr_desc_store.sv
module txr_desc_store
    import txr_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  txr_desc_t     wdata,
    input  logic          rel_valid,
    input  logic [IW-1:0] rel_idx,
    input  logic [IW-1:0] sidx,
    output txr_desc_t     sword,
    input  logic [IW-1:0] oidx,
    output txr_desc_t     oword
);
    txr_desc_t mem [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_ent
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                                 mem[g] <= '0;
                else if (clr)                               mem[g] <= '0;
                else if (we && widx == IW'(g))              mem[g] <= wdata;
                else if (rel_valid && rel_idx == IW'(g))    mem[g].own <= 1'b0;
            end
        end
    endgenerate

    assign sword = mem[sidx];
    assign oword = mem[oidx];

    // A descriptor handed back (not rewritten) must show its owner bit clear
    AST_REL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && !clr && !(we && widx == rel_idx)) |=> (mem[$past(rel_idx)].own == 1'b0)); // R7
endmodule

// File: rtl/txr_wdog.sv
module txr_wdog #(
    parameter int LOAD = 5,
    localparam int CW = $clog2(LOAD + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic load,
    input  logic tick,
    output logic expired
);
    logic [CW-1:0] cnt_q;
    logic          exp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            exp_q <= 1'b0;
        end else begin
            exp_q <= !clr && !load && tick && (cnt_q == CW'(1));
            if (clr)                        cnt_q <= '0;
            else if (load)                  cnt_q <= CW'(LOAD);
            else if (tick && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = exp_q;

    AST_WDOG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LOAD)); // R9
    AST_WDOG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        expired |-> (cnt_q == '0)); // R10
endmodule

// File: rtl/txr_ring_ctrl.sv
module txr_ring_ctrl
    import txr_pkg::*;
#(
    parameter int PHYS_DEPTH = 16,
    parameter int LOG_DEPTH  = 8,
    parameter int HI_WM      = 5,
    parameter int LO_WM      = 2,
    parameter int WD_LOAD    = 5,
    parameter int MASK_W     = 32,
    localparam int IW = $clog2(PHYS_DEPTH),
    localparam int BW = $clog2(LOG_DEPTH),
    localparam int CW = $clog2(LOG_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [10:0]       req_len,
    output logic              req_ready,
    output logic              doorbell,
    output logic [IW-1:0]     door_idx,
    output logic [BW-1:0]     buf_sel,
    input  logic              reclaim_req,
    input  logic              rel_valid,
    input  logic [IW-1:0]     rel_idx,
    input  logic              tick,
    output logic              timeout,
    output logic              full,
    output logic [CW-1:0]     count,
    output logic [MASK_W-1:0] irq_mask,
    input  logic [IW-1:0]     obs_idx,
    output logic [15:0]       obs_word
);
    localparam logic [CW-1:0] LOG_C = CW'(LOG_DEPTH);
    localparam logic [CW-1:0] HI_C  = CW'(HI_WM);
    localparam logic [CW-1:0] LO_C  = CW'(LO_WM);

    txr_state_t        state_q, state_nx;
    logic [LEN_W-1:0]  len_q;
    logic [CW-1:0]     count_q;
    logic              full_q;
    logic [MASK_W-1:0] mask_q;
    logic [IW-1:0]     prod_idx, cons_idx;
    txr_desc_t         scan_word, obs_desc, wr_desc;
    logic              flush, post, accept, scan_stop, scan_step, scan_end, drained;

    assign flush     = timeout;
    assign scan_stop = (count_q == '0) || scan_word.own;
    assign accept    = (state_q == ST_IDLE) && req_valid && !full_q && !reclaim_req && !flush;
    assign post      = (state_q == ST_POST) && !flush;
    assign scan_step = (state_q == ST_SCAN) && !scan_stop && !flush;
    assign scan_end  = (state_q == ST_SCAN) && scan_stop && !flush;
    assign drained   = scan_end && (count_q == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (reclaim_req)                  state_nx = ST_SCAN;
                else if (req_valid && !full_q)    state_nx = ST_POST;
            end
            ST_POST: state_nx = ST_IDLE;
            ST_SCAN: if (scan_stop) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
        if (flush) state_nx = ST_IDLE;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q   <= '0;
            count_q <= '0;
            full_q  <= 1'b0;
            mask_q  <= '1;
        end else if (flush) begin
            count_q <= '0;
            full_q  <= 1'b0;
            mask_q  <= '1;
        end else begin
            if (accept) len_q <= req_len;
            if (post) begin
                count_q <= count_q + 1'b1;
                full_q  <= (count_q + 1'b1) == LOG_C;
                if ((count_q + 1'b1) > HI_C) mask_q <= '0;
            end else if (scan_step) begin
                count_q <= count_q - 1'b1;
                full_q  <= 1'b0;
            end else if (scan_end && count_q < LO_C) begin
                mask_q  <= '1;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE) && !full_q && !reclaim_req && !flush;
        doorbell  = post;
        door_idx  = prod_idx;
        buf_sel   = prod_idx[BW-1:0];
        wr_desc   = '{own: 1'b1, sop: 1'b1, eop: 1'b1, rsvd: 2'b00, len: len_q};
        full      = full_q;
        count     = count_q;
        irq_mask  = mask_q;
        obs_word  = obs_desc;
    end

    txr_ptr #(.DEPTH(PHYS_DEPTH)) i_prod (
        .clk(clk), .rst_n(rst_n), .clr(flush), .inc(post), .idx(prod_idx)
    );

    txr_ptr #(.DEPTH(PHYS_DEPTH)) i_cons (
        .clk(clk), .rst_n(rst_n), .clr(flush), .inc(scan_step), .idx(cons_idx)
    );

    txr_desc_store #(.DEPTH(PHYS_DEPTH)) i_store (
        .clk(clk), .rst_n(rst_n), .clr(flush),
        .we(post), .widx(prod_idx), .wdata(wr_desc),
        .rel_valid(rel_valid), .rel_idx(rel_idx),
        .sidx(cons_idx), .sword(scan_word),
        .oidx(obs_idx), .oword(obs_desc)
    );

    txr_wdog #(.LOAD(WD_LOAD)) i_wdog (
        .clk(clk), .rst_n(rst_n), .clr(flush || drained),
        .load(post), .tick(tick), .expired(timeout)
    );

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= LOG_C); // R4
    AST_FULL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        full_q == (count_q == LOG_C)); // R4
    AST_DOORBELL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        doorbell |=> !doorbell); // R2
    AST_PROD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (doorbell && door_idx == IW'(PHYS_DEPTH - 1)) |=> (prod_idx == '0)); // R3
    AST_SCAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && scan_word.own && !flush) |=> $stable(cons_idx)); // R6
    AST_TO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> (count_q == '0 && !full_q && prod_idx == '0)); // R10
endmodule

// File: tb/test_txr_ring_ctrl.sv
module test_txr_ring_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int PHYS = 16;
    localparam int LOGD = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [10:0] req_len = '0;
    logic        req_ready;
    logic        doorbell;
    logic [3:0]  door_idx;
    logic [2:0]  buf_sel;
    logic        reclaim_req = 1'b0;
    logic        rel_valid = 1'b0;
    logic [3:0]  rel_idx = '0;
    logic        tick = 1'b0;
    logic        timeout;
    logic        full;
    logic [3:0]  count;
    logic [31:0] irq_mask;
    logic [3:0]  obs_idx = '0;
    logic [15:0] obs_word;

    int n_chk = 0;
    int n_bad = 0;
    int exp_prod = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txr_ring_ctrl i_txr_ring_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_len(req_len),
        .req_ready(req_ready), .doorbell(doorbell), .door_idx(door_idx),
        .buf_sel(buf_sel), .reclaim_req(reclaim_req), .rel_valid(rel_valid),
        .rel_idx(rel_idx), .tick(tick), .timeout(timeout), .full(full),
        .count(count), .irq_mask(irq_mask), .obs_idx(obs_idx), .obs_word(obs_word)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_word(int idx, logic [15:0] exp, string req);
        obs_idx = 4'(idx);
        #1;
        check(req, 32'(obs_word), 32'(exp));
    endtask

    // starts and ends at a falling edge
    task automatic queue_frame(logic [10:0] len);
        req_valid = 1'b1;
        req_len   = len;
        @(negedge clk);
        check("R2 doorbell", 32'(doorbell), 1);
        check("R3 door_idx", 32'(door_idx), 32'(exp_prod));
        check("R3 buf_sel", 32'(buf_sel), 32'(exp_prod % LOGD));
        req_valid = 1'b0;
        @(negedge clk);
        check("R2 single pulse", 32'(doorbell), 0);
        exp_prod = (exp_prod + 1) % PHYS;
    endtask

    task automatic hand_back(int idx);
        rel_valid = 1'b1;
        rel_idx   = 4'(idx);
        @(negedge clk);
        rel_valid = 1'b0;
    endtask

    task automatic reclaim();
        reclaim_req = 1'b1;
        @(negedge clk);
        reclaim_req = 1'b0;
        repeat (PHYS + 2) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R11 count", 32'(count), 0);
        check("R11 full", 32'(full), 0);
        check("R11 mask", irq_mask, 32'hFFFF_FFFF);
        check("R11 doorbell", 32'(doorbell), 0);
        check("R11 timeout", 32'(timeout), 0);
        check("R11 ready", 32'(req_ready), 1);
    endtask

    task automatic t_basic();
        queue_frame(11'h040);
        check_word(0, 16'hE040, "R1 control word");
        check("R1 count", 32'(count), 1);
        check("R5 mask stays", irq_mask, 32'hFFFF_FFFF);
    endtask

    task automatic t_fill();
        queue_frame(11'h03C);
        queue_frame(11'h5EE);
        queue_frame(11'h7FF);
        queue_frame(11'h010);
        check("R5 at HI_WM masked", irq_mask, 32'hFFFF_FFFF);
        check_word(3, 16'hE7FF, "R1 max length");
        queue_frame(11'h001);
        check("R5 unmask above HI_WM", irq_mask, 32'h0);
        queue_frame(11'h002);
        queue_frame(11'h003);
        check("R4 count full", 32'(count), 8);
        check("R4 full flag", 32'(full), 1);
        check("R4 ready low", 32'(req_ready), 0);
        req_valid = 1'b1;
        req_len   = 11'h0AA;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R4 no doorbell when full", 32'(doorbell), 0);
        end
        req_valid = 1'b0;
        @(negedge clk);
        check("R4 count unchanged", 32'(count), 8);
    endtask

    task automatic t_partial();
        hand_back(0);
        hand_back(1);
        hand_back(2);
        reclaim();
        check("R7 count lowered", 32'(count), 5);
        check("R7 full cleared", 32'(full), 0);
        check("R8 mask between marks", irq_mask, 32'h0);
        check_word(3, 16'hE7FF, "R6 stop keeps owner");
        check_word(0, 16'h6040, "R7 owner cleared");
    endtask

    task automatic t_drain();
        for (int i = 3; i < 7; i++) hand_back(i);
        reclaim();
        check("R7 count one", 32'(count), 1);
        check("R8 mask below LO_WM", irq_mask, 32'hFFFF_FFFF);
        hand_back(7);
        reclaim();
        check("R6 stop at empty", 32'(count), 0);
        for (int i = 0; i < 6; i++) begin
            tick = 1'b1;
            @(negedge clk);
            check("R9 drained no timeout", 32'(timeout), 0);
        end
        tick = 1'b0;
    endtask

    task automatic t_wrap();
        for (int i = 0; i < 8; i++) queue_frame(11'(16 + i));
        check("R4 full after wrap fill", 32'(full), 1);
        for (int i = 8; i < 16; i++) hand_back(i);
        reclaim();
        check("R7 drained", 32'(count), 0);
        queue_frame(11'h020);
        check("R3 wrapped index", 32'(exp_prod), 1);
        check_word(0, 16'hE020, "R3 word at index 0");
    endtask

    task automatic t_timeout();
        for (int i = 0; i < 4; i++) begin
            tick = 1'b1;
            @(negedge clk);
            check("R9 no early timeout", 32'(timeout), 0);
        end
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        check("R10 timeout pulse", 32'(timeout), 1);
        @(negedge clk);
        check("R10 pulse ends", 32'(timeout), 0);
        check("R10 count cleared", 32'(count), 0);
        check("R10 mask set", irq_mask, 32'hFFFF_FFFF);
        check_word(0, 16'h0000, "R10 words cleared");
        exp_prod = 0;
        queue_frame(11'h055);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_fill();
        t_partial();
        t_drain();
        t_wrap();
        t_timeout();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule